// File: doc/BRIEF.md
# Serial Addressed Configuration Port

This block is a write-only configuration port that loads a bank of control registers from three serial pins: a serial clock, a serial data line and an active-low enable. While the enable is low, one bit is taken from the data line on every rising edge of the serial clock. Each word is 22 bits long: an 18-bit data field followed by a 4-bit address. When the enable returns high, the data field is written to the register that the address selects.

The bank holds nine registers: a main configuration word, a gain word, a power word, three loop dividers and three reference dividers. Addresses 9 to 15 are reserved, and a write to one of them is dropped. Writing a divider that belongs to one of the two RF loops makes that loop the active one. Any divider write also sends a one-cycle strobe, tagged with the loop it affects, so that downstream logic can restart that loop's tuning.

The enable's rising edge is brought into the system clock domain through a synchronizer, and the write happens in that domain. The shift register is left untouched from the moment the enable goes high, so it can be read safely across the two clock domains.

Top module: `cfg_serial_port`

## Requirements
- R1: While `ser_en_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into the word. The word is sent most significant bit first: data bits 17 down to 0, then address bits 3 down to 0.
- R2: After `ser_en_n` rises, within 4 `clk` cycles the 18-bit data field is written to register number `addr` (0 to 8). Register i appears at `regs_o[18*i+17 : 18*i]`, and no other register changes.
- R3: While `ser_en_n` is high, `ser_clk` and `ser_dat` are ignored. Raising the enable again with no new bits commits the same word again.
- R4: Any number of leading bits may come before the word. Only the last 22 bits shifted decide the write.
- R5: A write to address 9 to 15 changes no register, leaves `rf_sel` unchanged and produces no strobe.
- R6: `rf_sel` becomes 0 (first RF loop) on a write to address 3 or 6, and 1 (second RF loop) on a write to address 4 or 7. Writes to any other address leave it unchanged.
- R7: Reset (`rst_n` low) clears every register, sets `rf_sel` to 0 and holds `freq_stb` low.
- R8: A write to address 3 to 8 raises `freq_stb` for exactly one `clk` cycle, with the loop on `freq_tag`: 0 for addresses 3 and 6, 1 for addresses 4 and 7, 2 for addresses 5 and 8. Writes to addresses 0 to 2 raise no strobe.
- R9: Writes are accepted whatever the power register (address 2) holds, including all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low enable; its rising edge commits the word |
| regs_o | output | 162 | All nine registers, register i at bits 18*i+17 to 18*i |
| rf_sel | output | 1 | Active RF loop: 0 is the first loop, 1 is the second |
| freq_stb | output | 1 | One-cycle strobe when a divider is written |
| freq_tag | output | 2 | Loop of the strobe: 0 first RF, 1 second RF, 2 IF |

## Verification
The assertions check on every cycle the following behaviour:
- The register bank and `rf_sel` hold still unless a commit occurs.
- A reserved address leaves both unchanged and raises no strobe.
- The strobe never lasts more than one cycle and never carries tag 3.
- Writes to the RF divider addresses set `rf_sel` to the matching loop.

Some behaviour only the bench scenarios can show, because it depends on the serial bit order and what happens across whole transactions:
- Bits are placed most significant first.
- Extra leading bits fall away.
- Clock pulses sent while the enable is high leave no trace.
- Each write lands in the right 18-bit slice.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int RF1_N_ADDR  = 3,
  parameter int RF2_N_ADDR  = 4,
  parameter int IF_N_ADDR   = 5,
  parameter int RF1_R_ADDR  = 6,
  parameter int RF2_R_ADDR  = 7,
  parameter int IF_R_ADDR   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_dat,
  input  logic                       ser_en_n,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       rf_sel,
  output logic                       freq_stb,
  output logic [1:0]                 freq_tag
);
  localparam int WORD_W = DATA_W + ADDR_W;

  logic [WORD_W-1:0]      shreg;
  logic [SYNC_STAGES:0]   en_q;
  logic                   commit;
  logic [ADDR_W-1:0]      waddr;
  logic [DATA_W-1:0]      wdata;
  logic                   is_rf1, is_rf2, is_if;
  logic [DATA_W-1:0]      regs_q [NUM_REGS];

  always_ff @(posedge ser_clk or negedge rst_n)
    if (!rst_n)         shreg <= '0;
    else if (!ser_en_n) shreg <= {shreg[WORD_W-2:0], ser_dat};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '1;
    else        en_q <= {en_q[SYNC_STAGES-1:0], ser_en_n};

  assign commit = en_q[SYNC_STAGES-1] & ~en_q[SYNC_STAGES];
  assign waddr  = shreg[ADDR_W-1:0];
  assign wdata  = shreg[WORD_W-1:ADDR_W];

  assign is_rf1 = (int'(waddr) == RF1_N_ADDR) || (int'(waddr) == RF1_R_ADDR);
  assign is_rf2 = (int'(waddr) == RF2_N_ADDR) || (int'(waddr) == RF2_R_ADDR);
  assign is_if  = (int'(waddr) == IF_N_ADDR)  || (int'(waddr) == IF_R_ADDR);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                              regs_q[i] <= '0;
      else if (commit && int'(waddr) == i)     regs_q[i] <= wdata;
    assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rf_sel   <= 1'b0;
      freq_stb <= 1'b0;
      freq_tag <= 2'd0;
    end else begin
      freq_stb <= commit && (is_rf1 || is_rf2 || is_if);
      if (commit && is_rf1) rf_sel <= 1'b0;
      if (commit && is_rf2) rf_sel <= 1'b1;
      if (commit) freq_tag <= is_rf2 ? 2'd1 : (is_if ? 2'd2 : 2'd0);
    end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 4,
  parameter int NUM_REGS   = 9,
  parameter int RF1_N_ADDR = 3,
  parameter int RF2_N_ADDR = 4,
  parameter int RF1_R_ADDR = 6,
  parameter int RF2_R_ADDR = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       commit,
  input logic [ADDR_W-1:0]          waddr,
  input logic [NUM_REGS*DATA_W-1:0] regs_o,
  input logic                       rf_sel,
  input logic                       freq_stb,
  input logic [1:0]                 freq_tag
);
  assert_hold_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_o));

  assert_reserved_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && int'(waddr) >= NUM_REGS) |=> ($stable(regs_o) && $stable(rf_sel) && !freq_stb));

  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rf_sel));

  assert_sel_rf1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (int'(waddr) == RF1_N_ADDR || int'(waddr) == RF1_R_ADDR)) |=> !rf_sel);

  assert_sel_rf2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (int'(waddr) == RF2_N_ADDR || int'(waddr) == RF2_R_ADDR)) |=> rf_sel);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_stb |=> !freq_stb);

  assert_tag_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_stb |-> freq_tag != 2'd3);

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R7: assert (!freq_stb);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
  .RF1_N_ADDR(RF1_N_ADDR), .RF2_N_ADDR(RF2_N_ADDR),
  .RF1_R_ADDR(RF1_R_ADDR), .RF2_R_ADDR(RF2_R_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .waddr(waddr),
  .regs_o(regs_o), .rf_sel(rf_sel), .freq_stb(freq_stb), .freq_tag(freq_tag)
);

// File: tb/cfg_serial_port_bench.sv
`timescale 1ns/1ps
module cfg_serial_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [161:0] regs_o;
  logic rf_sel, freq_stb;
  logic [1:0] freq_tag;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .regs_o(regs_o), .rf_sel(rf_sel), .freq_stb(freq_stb), .freq_tag(freq_tag));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int stb_cnt = 0;
  logic [1:0] last_tag = 2'd0;
  logic [17:0] exp_reg [9];
  logic exp_sel = 1'b0;
  int exp_stb = 0;
  logic [1:0] exp_tag = 2'd0;

  always @(negedge clk) if (freq_stb) begin stb_cnt++; last_tag = freq_tag; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tag_of(input int a);
    return (a == 4 || a == 7) ? 2'd1 : ((a == 5 || a == 8) ? 2'd2 : 2'd0);
  endfunction

  task automatic model(input logic [21:0] w);
    int a = int'(w[3:0]);
    if (a < 9) exp_reg[a] = w[21:4];
    if (a == 3 || a == 6) exp_sel = 1'b0;
    if (a == 4 || a == 7) exp_sel = 1'b1;
    if (a >= 3 && a <= 8) begin exp_stb++; exp_tag = tag_of(a); end
  endtask

  task automatic clock_bit(input logic b);
    ser_dat = b; #10 ser_clk = 1'b1; #10 ser_clk = 1'b0;
  endtask

  task automatic finish_commit(input string req);
    #10 ser_en_n = 1'b1;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 9; i++) chk(req, 32'(regs_o[i*18 +: 18]), 32'(exp_reg[i]));
    chk({req, " rf_sel R6"}, 32'(rf_sel), 32'(exp_sel));
    chk({req, " strobe count R8"}, stb_cnt, exp_stb);
    if (exp_stb > 0) chk({req, " tag R8"}, 32'(last_tag), 32'(exp_tag));
  endtask

  task automatic send(input logic [21:0] w, input int lead, input string req);
    ser_en_n = 1'b0;
    for (int i = 0; i < lead; i++) clock_bit(1'($urandom));
    for (int i = 21; i >= 0; i--) clock_bit(w[i]);
    model(w);
    finish_commit(req);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) exp_reg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 regs zero", 32'(regs_o == '0), 32'd1);
    chk("R7 rf_sel", 32'(rf_sel), 32'd0);
    chk("R7 no strobe", stb_cnt, 0);

    send({18'h2A5C3, 4'd0}, 0, "R1 R2 msb-first cfg");
    send({18'h00000, 4'd2}, 0, "R9 power all zero");
    send({18'h1F0F0, 4'd3}, 0, "R9 write after power-down R6");
    send({18'h3FFFF, 4'd4}, 0, "R6 rf2 n-divider");
    send({18'h12345, 4'd6}, 0, "R6 rf1 r-divider");
    send({18'h0ABCD, 4'd7}, 0, "R6 rf2 r-divider");
    send({18'h00055, 4'd5}, 0, "R8 if divider keeps sel");
    send({18'h3C3C3, 4'd9}, 0, "R5 reserved 9");
    send({18'h11111, 4'd15}, 0, "R5 reserved 15");
    send({18'h2FEED, 4'd8}, 7, "R4 leading bits");
    send({18'h00001, 4'd1}, 3, "R4 leading bits gain");

    send({18'h1BEEF, 4'd5}, 0, "R3 setup");
    for (int i = 0; i < 22; i++) clock_bit(1'($urandom));
    ser_en_n = 1'b0;
    model({18'h1BEEF, 4'd5});
    finish_commit("R3 clocks ignored while enable high");

    for (int n = 0; n < 40; n++) begin
      logic [21:0] w;
      w = 22'($urandom);
      send(w, int'($urandom_range(0, 5)), "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule